// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register interface that sits in front of a three-channel interval timer. Software reaches it through a 2-bit address with separate write and read strobes carrying one byte each. Address 3 accepts command bytes; addresses 0, 1 and 2 are the count ports of channels 0, 1 and 2. From command bytes the block keeps, for every channel, an operating mode, a decimal-counting flag and a byte-access mode, and presents them to the counting logic, which is a separate block.

Count writes are assembled here into 16-bit initial values and handed to the counting logic as a one-cycle load strobe per channel. Reads return either the live count that the counting logic presents, a count frozen by a latch command, or a status byte frozen by a multi-channel read-back command. Word-mode accesses are sequenced low byte first. The strobes are plain single-cycle requests with no back-pressure: every accepted strobe is served in the same cycle, and read data comes back with a valid flag exactly one cycle later. If both strobes are raised together, the write is performed and the read is dropped.

Top module: `tmr_regfront`

## Requirements
- R1: After reset every channel reports mode 0, decimal flag 0 and access mode 1 (low byte only), no latched count or status is held, and `rd_valid` and all load strobes are low.
- R2: A write to address 3 whose bits 7:6 name a channel (0 to 2) and whose bits 5:4 are non-zero sets that channel's access mode from bits 5:4, its decimal flag from bit 0 and its mode from bits 3:1, with mode codes 6 and 7 stored as 2 and 3.
- R3: Such a command resets that channel's write and read byte pointers, so the next word-mode write or unlatched read is treated as the low byte.
- R4: A count-port write in access mode 1 loads {8'h00, byte}; in access mode 2 it loads {byte, 8'h00}. The channel's load strobe is high for exactly the one cycle after the write, with the value, and at most one channel strobes at a time.
- R5: In access mode 3 the first count-port write is held without a load; the second loads {second byte, first byte}, after which the sequence starts over.
- R6: A command with bits 5:4 equal to 0 freezes the channel's live count; later reads return it per the access mode in force at latch time (low only, high only, or low then high), after which the latch is released and reads show the live count again.
- R7: A count latch request, or a status latch request, for a channel that still holds an unread latched value of the same kind leaves the held value unchanged.
- R8: A write to address 3 with bits 7:6 equal to 3 is a read-back: bits 1, 2 and 3 select channels 0, 1 and 2; bit 5 clear requests a count latch and bit 4 clear a status latch for each selected channel; the channel configuration is not changed.
- R9: A latched status byte is {live output, 0, access mode, mode, decimal flag} (bit 7 down to bit 0), captured at the command; on a read it is returned before any latched count and is then cleared.
- R10: Unlatched reads return the live count's low byte in access mode 1, its high byte in mode 2, and alternate low then high in mode 3.
- R11: `rd_valid` is high exactly in the cycle after an accepted read, with `rd_data`; a read of address 3 returns 8'h00 and changes nothing.
- R12: When `wr_en` and `rd_en` are high in the same cycle, the write takes effect and the read is ignored (no `rd_valid`, no read side effect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Port address: 0-2 count ports, 3 command port |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rd_data | output | 8 | Read byte, valid with `rd_valid` |
| rd_valid | output | 1 | High the cycle after an accepted read |
| ch_mode | output | 3x3 | Per-channel operating mode (0-5) |
| ch_bcd | output | 3 | Per-channel decimal counting flag |
| ch_access | output | 3x2 | Per-channel byte-access mode (1-3) |
| ch_live_cnt | input | 3x16 | Live count from the counting logic |
| ch_live_out | input | 3 | Live output pin level from the counting logic |
| ch_load_stb | output | 3 | One-cycle count load request |
| ch_load_val | output | 3x16 | Count value to load, valid with the strobe |

## Verification
The hardest state to reach is a channel holding both a latched status and a word-mode latched count that is half read, while a further latch command arrives and the live count has moved on; only then do status priority, the low-then-high latch sequence and the ignore rule all show at once. The stimulus builds it directly with one read-back command covering all three channels in different access modes, a live-count change, a repeated latch and interleaved reads, and then a long random mix of commands, count writes and reads over fresh live values keeps revisiting half-finished sequences that a bench model tracks byte by byte.

// File: rtl/tmr_regfront_pkg.sv
package tmr_regfront_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  // Codes 6 and 7 alias modes 2 and 3.
  function automatic logic [2:0] fold_mode(input logic [2:0] code);
    if (code[2] && code[1]) fold_mode = {1'b0, code[1:0]};
    else                    fold_mode = code;
  endfunction

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:1]        cmd,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [NUM_CH-1:0] cnt_lreq,
  output logic [NUM_CH-1:0] st_lreq,
  output logic [NUM_CH-1:0] data_we,
  output logic [NUM_CH-1:0] rd_hit
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = {ADDR_W{1'b1}};
  localparam logic [1:0]        RB_SEL   = 2'd3;

  logic cmd_wr, is_rb, acc_zero;

  assign cmd_wr   = wr_go && (addr == CMD_ADDR);
  assign is_rb    = cmd[7:6] == RB_SEL;
  assign acc_zero = cmd[5:4] == 2'd0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic named, rb_sel;
    assign named       = !is_rb && (cmd[7:6] == 2'(c));
    assign rb_sel      = is_rb && cmd[1+c];
    assign cfg_we[c]   = cmd_wr && named && !acc_zero;
    assign cnt_lreq[c] = cmd_wr && ((named && acc_zero) || (rb_sel && !cmd[5]));
    assign st_lreq[c]  = cmd_wr && rb_sel && !cmd[4];
    assign data_we[c]  = wr_go && (addr == ADDR_W'(c));
    assign rd_hit[c]   = rd_go && (addr == ADDR_W'(c));
  end

endmodule

// File: rtl/tmr_chan_write.sv
module tmr_chan_write
  import tmr_regfront_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_byte,
  input  logic             data_we,
  input  logic [7:0]       data_byte,
  output logic [2:0]       mode,
  output logic             bcd,
  output acc_e             access,
  output logic             load_stb,
  output logic [CNT_W-1:0] load_val
);
  localparam int BYTE_W = CNT_W / 2;

  logic              wptr;
  logic [BYTE_W-1:0] whold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= '0;
      bcd      <= 1'b0;
      access   <= ACC_LO;
      wptr     <= 1'b0;
      whold    <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      load_stb <= 1'b0;
      if (cfg_we) begin
        access <= acc_e'(cfg_byte[5:4]);
        mode   <= fold_mode(cfg_byte[3:1]);
        bcd    <= cfg_byte[0];
        wptr   <= 1'b0;
      end else if (data_we) begin
        unique case (access)
          ACC_LO: begin
            load_stb <= 1'b1;
            load_val <= {{BYTE_W{1'b0}}, data_byte};
          end
          ACC_HI: begin
            load_stb <= 1'b1;
            load_val <= {data_byte, {BYTE_W{1'b0}}};
          end
          ACC_WORD: begin
            if (!wptr) begin
              whold <= data_byte;
              wptr  <= 1'b1;
            end else begin
              load_stb <= 1'b1;
              load_val <= {data_byte, whold};
              wptr     <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  word_first_nostb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !cfg_we && access == ACC_WORD && !wptr) |=> !load_stb);

  // R4
  hi_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && access == ACC_HI) |-> (load_val[BYTE_W-1:0] == '0));

  // R3
  cfg_clears_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_byte[5:4] == 2'd3) ##1 (data_we && !cfg_we) |=> !load_stb);

endmodule

// File: rtl/tmr_chan_readout.sv
module tmr_chan_readout
  import tmr_regfront_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cnt_lreq,
  input  logic             st_lreq,
  input  logic             rd_hit,
  input  logic [2:0]       mode,
  input  logic             bcd,
  input  acc_e             access,
  input  logic [CNT_W-1:0] live_cnt,
  input  logic             live_out,
  output logic [7:0]       rd_byte
);
  localparam int BYTE_W = CNT_W / 2;

  logic             st_lat;
  logic [7:0]       st_val;
  acc_e             cl_state;
  logic [CNT_W-1:0] cl_val;
  logic             rptr;

  always_comb begin
    if (st_lat) begin
      rd_byte = st_val;
    end else if (cl_state != ACC_NONE) begin
      rd_byte = (cl_state == ACC_HI) ? cl_val[CNT_W-1:BYTE_W] : cl_val[BYTE_W-1:0];
    end else begin
      unique case (access)
        ACC_HI:   rd_byte = live_cnt[CNT_W-1:BYTE_W];
        ACC_WORD: rd_byte = rptr ? live_cnt[CNT_W-1:BYTE_W] : live_cnt[BYTE_W-1:0];
        default:  rd_byte = live_cnt[BYTE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_lat   <= 1'b0;
      st_val   <= '0;
      cl_state <= ACC_NONE;
      cl_val   <= '0;
      rptr     <= 1'b0;
    end else begin
      if (rd_hit) begin
        if (st_lat) begin
          st_lat <= 1'b0;
        end else if (cl_state != ACC_NONE) begin
          cl_state <= (cl_state == ACC_WORD) ? ACC_HI : ACC_NONE;
        end else if (access == ACC_WORD) begin
          rptr <= !rptr;
        end
      end
      if (cnt_lreq && cl_state == ACC_NONE) begin
        cl_state <= access;
        cl_val   <= live_cnt;
      end
      if (st_lreq && !st_lat) begin
        st_lat <= 1'b1;
        st_val <= {live_out, 1'b0, access, mode, bcd};
      end
      if (cfg_we) rptr <= 1'b0;
    end
  end

  // R7
  cnt_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_state != ACC_NONE && !rd_hit) |=> $stable(cl_val));

  // R7
  st_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_lat && !rd_hit) |=> (st_lat && $stable(st_val)));

  // R9
  st_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && st_lat && !cnt_lreq) |=> (cl_state == $past(cl_state)));

endmodule

// File: rtl/tmr_regfront.sv
module tmr_regfront
  import tmr_regfront_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   addr,
  input  logic                         wr_en,
  input  logic [7:0]                   wr_data,
  input  logic                         rd_en,
  output logic [7:0]                   rd_data,
  output logic                         rd_valid,
  output logic [NUM_CH-1:0][2:0]       ch_mode,
  output logic [NUM_CH-1:0]            ch_bcd,
  output logic [NUM_CH-1:0][1:0]       ch_access,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ch_live_cnt,
  input  logic [NUM_CH-1:0]            ch_live_out,
  output logic [NUM_CH-1:0]            ch_load_stb,
  output logic [NUM_CH-1:0][CNT_W-1:0] ch_load_val
);
  localparam int ADDR_W = 2;

  logic                   wr_go, rd_go;
  logic [NUM_CH-1:0]      cfg_we, cnt_lreq, st_lreq, data_we, rd_hit;
  logic [NUM_CH-1:0][7:0] rd_bytes;
  logic [7:0]             rd_sel;

  assign wr_go = wr_en;
  assign rd_go = rd_en && !wr_en;

  tmr_cmd_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
    .wr_go    (wr_go),
    .rd_go    (rd_go),
    .addr     (addr),
    .cmd      (wr_data[7:1]),
    .cfg_we   (cfg_we),
    .cnt_lreq (cnt_lreq),
    .st_lreq  (st_lreq),
    .data_we  (data_we),
    .rd_hit   (rd_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    acc_e acc_c;

    tmr_chan_write #(.CNT_W(CNT_W)) wr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we[c]),
      .cfg_byte  (wr_data),
      .data_we   (data_we[c]),
      .data_byte (wr_data),
      .mode      (ch_mode[c]),
      .bcd       (ch_bcd[c]),
      .access    (acc_c),
      .load_stb  (ch_load_stb[c]),
      .load_val  (ch_load_val[c])
    );

    assign ch_access[c] = acc_c;

    tmr_chan_readout #(.CNT_W(CNT_W)) rd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we[c]),
      .cnt_lreq (cnt_lreq[c]),
      .st_lreq  (st_lreq[c]),
      .rd_hit   (rd_hit[c]),
      .mode     (ch_mode[c]),
      .bcd      (ch_bcd[c]),
      .access   (acc_c),
      .live_cnt (ch_live_cnt[c]),
      .live_out (ch_live_out[c]),
      .rd_byte  (rd_bytes[c])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(c)) rd_sel = rd_bytes[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= rd_sel;
    end
  end

  // R11
  rd_valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_valid == !$past(wr_en)));

  // R12
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> !rd_valid);

  // R4
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load_stb));

  // R4
  load_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load_stb != '0) |-> ($past(wr_en) && $past(addr) != 2'd3));

endmodule

// File: tb/tmr_regfront_tb_top.sv
`timescale 1ns/1ps
module tmr_regfront_tb_top;
  localparam int NCH = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [1:0]          addr = '0;
  logic                wr_en = 1'b0;
  logic [7:0]          wr_data = '0;
  logic                rd_en = 1'b0;
  logic [7:0]          rd_data;
  logic                rd_valid;
  logic [NCH-1:0][2:0] ch_mode;
  logic [NCH-1:0]      ch_bcd;
  logic [NCH-1:0][1:0] ch_access;
  logic [NCH-1:0][15:0] ch_live_cnt = '0;
  logic [NCH-1:0]      ch_live_out = '0;
  logic [NCH-1:0]      ch_load_stb;
  logic [NCH-1:0][15:0] ch_load_val;

  always #2 clk = ~clk;

  tmr_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_access(ch_access),
    .ch_live_cnt(ch_live_cnt), .ch_live_out(ch_live_out),
    .ch_load_stb(ch_load_stb), .ch_load_val(ch_load_val)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model
  int m_mode[NCH], m_bcd[NCH], m_acc[NCH], m_wptr[NCH], m_whold[NCH], m_rptr[NCH];
  int m_stl[NCH], m_stv[NCH], m_cl[NCH], m_clv[NCH];
  int e_stb[NCH], e_val[NCH];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fold(int m);
    return (m > 5) ? m - 4 : m;
  endfunction

  task automatic m_latch_cnt(int c);
    if (m_cl[c] == 0) begin
      m_cl[c]  = m_acc[c];
      m_clv[c] = int'(ch_live_cnt[c]);
    end
  endtask

  task automatic m_latch_st(int c);
    if (m_stl[c] == 0) begin
      m_stl[c] = 1;
      m_stv[c] = (int'(ch_live_out[c]) << 7) | (m_acc[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
    end
  endtask

  task automatic m_write(int a, int d);
    for (int c = 0; c < NCH; c++) begin e_stb[c] = 0; e_val[c] = 0; end
    if (a == 3) begin
      int sel = (d >> 6) & 3;
      int acc = (d >> 4) & 3;
      if (sel == 3) begin
        for (int c = 0; c < NCH; c++)
          if (d & (2 << c)) begin
            if (!(d & 32)) m_latch_cnt(c);
            if (!(d & 16)) m_latch_st(c);
          end
      end else if (acc == 0) begin
        m_latch_cnt(sel);
      end else begin
        m_acc[sel] = acc; m_mode[sel] = fold((d >> 1) & 7); m_bcd[sel] = d & 1;
        m_wptr[sel] = 0; m_rptr[sel] = 0;
      end
    end else begin
      case (m_acc[a])
        1: begin e_stb[a] = 1; e_val[a] = d; end
        2: begin e_stb[a] = 1; e_val[a] = d << 8; end
        default: begin
          if (m_wptr[a] == 0) begin m_whold[a] = d; m_wptr[a] = 1; end
          else begin e_stb[a] = 1; e_val[a] = (d << 8) | m_whold[a]; m_wptr[a] = 0; end
        end
      endcase
    end
  endtask

  task automatic check_cfg(string tag);
    for (int c = 0; c < NCH; c++) begin
      check(tag, int'(ch_mode[c]), m_mode[c]);
      check(tag, int'(ch_bcd[c]), m_bcd[c]);
      check(tag, int'(ch_access[c]), m_acc[c]);
    end
  endtask

  task automatic check_load(string tag);
    for (int c = 0; c < NCH; c++) begin
      check(tag, int'(ch_load_stb[c]), e_stb[c]);
      if (e_stb[c] != 0) check(tag, int'(ch_load_val[c]), e_val[c]);
    end
  endtask

  task automatic wr(int a, int d, string tag);
    @(negedge clk);
    addr = 2'(a); wr_data = 8'(d); wr_en = 1'b1;
    @(posedge clk);
    m_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 3) check_cfg((tag == "") ? "R2" : tag);
    else        check_load((tag == "") ? ((m_acc[a] == 3) ? "R5" : "R4") : tag);
  endtask

  task automatic rd(int a, string tag);
    int exp;
    string t;
    @(negedge clk);
    addr = 2'(a); rd_en = 1'b1;
    @(posedge clk);
    if (a == 3) begin
      exp = 0; t = "R11";
    end else if (m_stl[a] != 0) begin
      exp = m_stv[a]; m_stl[a] = 0; t = "R9";
    end else if (m_cl[a] != 0) begin
      t = "R6";
      if (m_cl[a] == 2) begin exp = (m_clv[a] >> 8) & 255; m_cl[a] = 0; end
      else begin exp = m_clv[a] & 255; m_cl[a] = (m_cl[a] == 3) ? 2 : 0; end
    end else begin
      t = "R10";
      if (m_acc[a] == 2) exp = int'(ch_live_cnt[a][15:8]);
      else if (m_acc[a] == 3) begin
        exp = m_rptr[a] ? int'(ch_live_cnt[a][15:8]) : int'(ch_live_cnt[a][7:0]);
        m_rptr[a] = 1 - m_rptr[a];
      end else exp = int'(ch_live_cnt[a][7:0]);
    end
    @(negedge clk);
    rd_en = 1'b0;
    check("R11", int'(rd_valid), 1);
    check((tag == "") ? t : tag, int'(rd_data), exp);
  endtask

  task automatic set_live();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) ch_live_cnt[c] = 16'($urandom);
    ch_live_out = 3'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin
      m_mode[c] = 0; m_bcd[c] = 0; m_acc[c] = 1; m_wptr[c] = 0; m_whold[c] = 0;
      m_rptr[c] = 0; m_stl[c] = 0; m_stv[c] = 0; m_cl[c] = 0; m_clv[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_cfg("R1");
    check("R1", int'(rd_valid), 0);
    check("R1", int'(ch_load_stb), 0);

    // R2 configuration, including folded codes 6 and 7
    wr(3, 8'b00_11_110_1, "R2");
    wr(3, 8'b01_01_111_0, "R2");
    wr(3, 8'b10_10_000_0, "R2");
    // R5 word load, R4 single-byte loads
    wr(0, 8'h34, "R5");
    wr(0, 8'h12, "R5");
    wr(1, 8'h5A, "R4");
    wr(2, 8'hAB, "R4");
    // R3 command restarts the byte sequence
    wr(0, 8'h77, "R3");
    wr(3, 8'b00_11_010_0, "R2");
    wr(0, 8'h11, "R3");
    wr(0, 8'h22, "R3");
    // R6/R7 count latch, repeat ignored
    @(negedge clk); ch_live_cnt[0] = 16'hBEEF;
    wr(3, 8'h00, "R6");
    @(negedge clk); ch_live_cnt[0] = 16'h1111;
    wr(3, 8'h00, "R7");
    rd(0, "R7");
    rd(0, "R7");
    rd(0, "R10");
    rd(0, "R10");
    // R8/R9 read-back of count and status on all channels
    @(negedge clk); ch_live_cnt[0] = 16'hA1B2; ch_live_cnt[1] = 16'hC3D4;
    ch_live_cnt[2] = 16'hE5F6; ch_live_out = 3'b101;
    wr(3, 8'b11_00_111_0, "R8");
    @(negedge clk); ch_live_cnt = '0; ch_live_out = 3'b010;
    wr(3, 8'b11_00_111_0, "R7");
    rd(0, "R9"); rd(0, "R8"); rd(0, "R8");
    rd(1, "R9"); rd(1, "R8");
    rd(2, "R9"); rd(2, "R8");
    // status only
    wr(3, 8'b11_10_001_0, "R8");
    rd(0, "R9");
    rd(0, "R10");
    // R12 simultaneous strobes on channel 1 (low-byte mode)
    @(negedge clk);
    addr = 2'd1; wr_data = 8'h99; wr_en = 1'b1; rd_en = 1'b1;
    @(posedge clk);
    m_write(1, 8'h99);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_load("R12");
    @(negedge clk);
    check("R12", int'(rd_valid), 0);
    // R11 command port read
    rd(3, "R11");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int op = int'($urandom % 10);
      set_live();
      if (op < 3)      wr(3, int'($urandom % 256), "");
      else if (op < 5) wr(int'($urandom % 3), int'($urandom % 256), "");
      else             rd(int'($urandom % 4), "");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule